// File: doc/BRIEF.md
# Flash command interface decoder

This block sits on the host side of a byte-wide flash memory. Each write strobe carries one command byte. The byte chooses what later reads return: array data passed through from the memory, an identifier code, or the status register. The block owns the status register and its sticky error flags. It also checks the order of the two-cycle erase sequence: a setup byte, then a confirm byte.

When a confirm arrives in the right order, the block checks two conditions first: the programming voltage must be valid, and the target block must not be locked unless the high-level unlock input is asserted. If both hold, it sends a one-cycle erase request and the block index to an external erase sequencer. If either check fails, it records the error instead. The sequencer's busy signal drives the ready bit of the status register. A failure reported by the sequencer sets the erase error flag.

A status read takes a snapshot on the first cycle of the read strobe. The snapshot is held until the strobe is released, so the host sees a stable value for the whole access.

Top module: `flash_cmd_dec`

## Requirements
- R1: After reset the read mode is array, erase_req_o is 0 and all sticky error flags are 0. A status read then returns 0x80 while the sequencer is idle.
- R2: After command 0xFF, rdata_o equals array_data_i.
- R3: After command 0x90, reads return identifier codes. Address 0 returns 0x89 and address 1 returns 0xA6. Offset 2 inside block b (block = addr[19:16]) returns {7'b0, blk_lock_i[b]}. Address 3 returns {7'b0, master_lock_i}. Every other address returns 0x00.
- R4: After command 0x70, every read returns the status register until another recognised command is written. An unrecognised byte, or 0xD0 written with no setup pending, leaves the mode unchanged.
- R5: Status layout: bit 7 = ready = !seq_busy_i, bit 5 = erase error, bit 4 = sequence error, bit 3 = voltage error, bit 1 = lock error. Bits 6, 2 and 0 read as 0.
- R6: Command 0x20 followed by 0xD0, with both checks passing, raises erase_req_o for exactly one cycle after the confirm write. erase_blk_o then holds addr_i[19:16] of the confirm write, and reads return status.
- R7: If 0x20 is followed by any byte other than 0xD0, bits 4 and 5 are set, no request is issued and reads return status.
- R8: A confirm written while vpp_ok_i=0 sets bits 3 and 5 and issues no request. The voltage check takes priority over the lock check.
- R9: A confirm to a locked block with unlock_hv_i=0 sets bits 1 and 5 and issues no request. With unlock_hv_i=1 the request is issued.
- R10: A cycle with seq_done_i=1 and seq_fail_i=1 sets bit 5.
- R11: Bits 5, 4, 3 and 1 stay set across other commands. Only command 0x50 clears them, and 0x50 has no effect while suspend_i=1.
- R12: While re_i stays high, a status read holds the value seen in the strobe's first cycle, even if the status changes in the meantime.
- R13: Identifier and status reads do not depend on vpp_ok_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Command write strobe, one cycle per byte |
| wdata_i | input | 8 | Command byte |
| addr_i | input | AW (20) | Byte address |
| re_i | input | 1 | Read strobe, held for the whole access |
| rdata_o | output | 8 | Read data |
| array_data_i | input | 8 | Data from the memory array |
| blk_lock_i | input | NBLK (16) | Per-block lock bits |
| master_lock_i | input | 1 | Device-wide lock bit |
| vpp_ok_i | input | 1 | Programming voltage valid |
| unlock_hv_i | input | 1 | High-level unlock override |
| suspend_i | input | 1 | Erase or write suspend active |
| seq_busy_i | input | 1 | Erase sequencer busy |
| seq_done_i | input | 1 | Sequencer finished, one-cycle pulse |
| seq_fail_i | input | 1 | Sequencer failure, qualified by seq_done_i |
| erase_req_o | output | 1 | Erase request pulse |
| erase_blk_o | output | AW-BW (4) | Block index to erase |

## Verification
The bench goes after several corner cases, each of which catches a specific design fault.
- A malformed erase sequence whose second byte is a valid mode command (0xFF). A decoder that treated that byte as a normal command would switch to array mode and record no error.
- A clear written during suspend. A design that ignored the suspend input would wipe error history that the host still needs.
- A locked-block erase run both with and without the unlock override, and a confirm with both the voltage and lock faults present. These catch inverted or reordered checks.
- A status change during a held read strobe, with the ready bit flipping. This catches a design with no snapshot, whose output would move under the host mid-access.
- A lone 0xD0 with no setup pending. This catches a decoder that starts an erase without a setup.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {MODE_ARRAY, MODE_ID, MODE_STAT} rd_mode_e;

  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_ID    = 8'h90;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_ER_SETUP = 8'h20;
  localparam logic [7:0] CMD_ER_GO    = 8'hD0;

  localparam logic [7:0] ID_MFR = 8'h89;
  localparam logic [7:0] ID_DEV = 8'hA6;

  typedef struct packed {
    logic erase;
    logic seq;
    logic vpp;
    logic lock;
  } err_set_t;
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int BKW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [7:0]     wdata_i,
  input  logic [BKW-1:0] blk_i,
  input  logic           blk_locked_i,
  input  logic           vpp_ok_i,
  input  logic           unlock_hv_i,
  output rd_mode_e       mode_o,
  output logic           pending_o,
  output logic           erase_req_o,
  output logic [BKW-1:0] erase_blk_o,
  output err_set_t       err_set_o,
  output logic           clr_req_o
);
  rd_mode_e       mode_q, mode_d;
  logic           pend_q, pend_d;
  logic           req_q, req_d;
  logic [BKW-1:0] blk_q, blk_d;

  always_comb begin
    mode_d    = mode_q;
    pend_d    = pend_q;
    req_d     = 1'b0;
    blk_d     = blk_q;
    err_set_o = '0;
    clr_req_o = 1'b0;
    if (we_i) begin
      if (pend_q) begin
        // second cycle of erase: any byte ends the setup
        pend_d = 1'b0;
        mode_d = MODE_STAT;
        if (wdata_i == CMD_ER_GO) begin
          if (!vpp_ok_i) begin
            err_set_o.vpp   = 1'b1;
            err_set_o.erase = 1'b1;
          end else if (blk_locked_i && !unlock_hv_i) begin
            err_set_o.lock  = 1'b1;
            err_set_o.erase = 1'b1;
          end else begin
            req_d = 1'b1;
            blk_d = blk_i;
          end
        end else begin
          err_set_o.seq   = 1'b1;
          err_set_o.erase = 1'b1;
        end
      end else begin
        unique case (wdata_i)
          CMD_RD_ARRAY: mode_d = MODE_ARRAY;
          CMD_RD_ID:    mode_d = MODE_ID;
          CMD_RD_STAT:  mode_d = MODE_STAT;
          CMD_CLR_STAT: clr_req_o = 1'b1;
          CMD_ER_SETUP: begin
            pend_d = 1'b1;
            mode_d = MODE_STAT;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ARRAY;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      blk_q  <= '0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
      req_q  <= req_d;
      blk_q  <= blk_d;
    end
  end

  assign mode_o      = mode_q;
  assign pending_o   = pend_q;
  assign erase_req_o = req_q;
  assign erase_blk_o = blk_q;
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  err_set_t   err_set_i,
  input  logic       clr_req_i,
  input  logic       suspend_i,
  input  logic       seq_busy_i,
  input  logic       seq_done_i,
  input  logic       seq_fail_i,
  input  logic       re_i,
  output logic [3:0] sticky_o,
  output logic [7:0] status_o
);
  logic [3:0] err_q, err_d, set_vec;
  logic       re_q;
  logic [7:0] snap_q, live;

  always_comb begin
    set_vec = err_set_i;
    set_vec[3] = err_set_i.erase | (seq_done_i & seq_fail_i);
    err_d = (clr_req_i && !suspend_i) ? 4'b0 : err_q;
    err_d = err_d | set_vec; // set wins over clear
  end

  assign live = {~seq_busy_i, 1'b0, err_q[3], err_q[2], err_q[1], 1'b0, err_q[0], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= '0;
      re_q   <= 1'b0;
      snap_q <= '0;
    end else begin
      err_q <= err_d;
      re_q  <= re_i;
      if (re_i && !re_q) snap_q <= live;
    end
  end

  assign status_o = (re_i && re_q) ? snap_q : live;
  assign sticky_o = err_q;
endmodule

// File: rtl/flash_id_space.sv
module flash_id_space
  import flash_cmd_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 16,
  localparam int BKW  = AW - BW,
  localparam int NBLK = 1 << BKW
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [NBLK-1:0] blk_lock_i,
  input  logic            master_lock_i,
  output logic [7:0]      id_o
);
  logic [BKW-1:0] blk;
  logic [BW-1:0]  off;

  assign blk = addr_i[AW-1:BW];
  assign off = addr_i[BW-1:0];

  always_comb begin
    id_o = 8'h00;
    if (off == BW'(2))                        id_o = {7'b0, blk_lock_i[blk]};
    else if (blk == '0 && off == BW'(0))      id_o = ID_MFR;
    else if (blk == '0 && off == BW'(1))      id_o = ID_DEV;
    else if (blk == '0 && off == BW'(3))      id_o = {7'b0, master_lock_i};
  end
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_cmd_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 16,
  localparam int BKW  = AW - BW,
  localparam int NBLK = 1 << BKW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [7:0]      wdata_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            re_i,
  output logic [7:0]      rdata_o,
  input  logic [7:0]      array_data_i,
  input  logic [NBLK-1:0] blk_lock_i,
  input  logic            master_lock_i,
  input  logic            vpp_ok_i,
  input  logic            unlock_hv_i,
  input  logic            suspend_i,
  input  logic            seq_busy_i,
  input  logic            seq_done_i,
  input  logic            seq_fail_i,
  output logic            erase_req_o,
  output logic [BKW-1:0]  erase_blk_o
);
  rd_mode_e       mode;
  logic           pending;
  err_set_t       err_set;
  logic           clr_req;
  logic [3:0]     sticky;
  logic [7:0]     status, id_code;
  logic [BKW-1:0] blk;

  assign blk = addr_i[AW-1:BW];

  flash_cmd_fsm #(.BKW(BKW)) u_fsm (
    .clk_i, .rst_ni, .we_i, .wdata_i,
    .blk_i        (blk),
    .blk_locked_i (blk_lock_i[blk]),
    .vpp_ok_i, .unlock_hv_i,
    .mode_o       (mode),
    .pending_o    (pending),
    .erase_req_o, .erase_blk_o,
    .err_set_o    (err_set),
    .clr_req_o    (clr_req)
  );

  flash_status_reg u_sr (
    .clk_i, .rst_ni,
    .err_set_i (err_set),
    .clr_req_i (clr_req),
    .suspend_i, .seq_busy_i, .seq_done_i, .seq_fail_i, .re_i,
    .sticky_o  (sticky),
    .status_o  (status)
  );

  flash_id_space #(.AW(AW), .BW(BW)) u_id (
    .addr_i, .blk_lock_i, .master_lock_i,
    .id_o (id_code)
  );

  always_comb begin
    unique case (mode)
      MODE_ID:   rdata_o = id_code;
      MODE_STAT: rdata_o = status;
      default:   rdata_o = array_data_i;
    endcase
  end
endmodule

// File: rtl/flash_cmd_dec_chk.sv
module flash_cmd_dec_chk
  import flash_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic [7:0] wdata_i,
  input logic       re_i,
  input logic       suspend_i,
  input logic       seq_busy_i,
  input logic       erase_req_o,
  input logic [7:0] rdata_o,
  input rd_mode_e   mode,
  input logic       pending,
  input logic [3:0] sticky
);
  // R6
  erase_req_from_confirm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> $past(we_i && pending && wdata_i == CMD_ER_GO));

  // R6
  erase_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |=> !erase_req_o);

  // R5
  ready_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_STAT && !re_i) |-> (rdata_o[7] == !seq_busy_i));

  // R11
  sticky_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(sticky) & ~sticky)) |-> $past(we_i && wdata_i == CMD_CLR_STAT && !suspend_i));

  // R7
  seq_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sticky[2]) |-> $past(we_i && pending && wdata_i != CMD_ER_GO));

  // R12
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && $past(re_i) && mode == MODE_STAT && $past(mode == MODE_STAT)) |-> $stable(rdata_o));
endmodule

bind flash_cmd_dec flash_cmd_dec_chk u_chk (
  .clk_i, .rst_ni, .we_i, .wdata_i, .re_i, .suspend_i, .seq_busy_i,
  .erase_req_o, .rdata_o,
  .mode    (mode),
  .pending (pending),
  .sticky  (sticky)
);

// File: tb/flash_cmd_dec_tb.sv
`timescale 1ns/1ps
module flash_cmd_dec_tb_top;
  localparam int AW = 20;
  localparam int BW = 16;
  localparam int BKW = AW - BW;
  localparam int NBLK = 1 << BKW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, re = 0;
  logic [7:0] wdata = 0, array_data = 0;
  logic [AW-1:0] addr = 0;
  logic [NBLK-1:0] blk_lock = 0;
  logic master_lock = 0, vpp_ok = 1, unlock_hv = 0, suspend = 0;
  logic seq_busy = 0, seq_done = 0, seq_fail = 0;
  logic [7:0] rdata;
  logic erase_req;
  logic [BKW-1:0] erase_blk;

  int checks = 0, errors = 0, req_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_cmd_dec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .wdata_i(wdata), .addr_i(addr),
    .re_i(re), .rdata_o(rdata), .array_data_i(array_data), .blk_lock_i(blk_lock),
    .master_lock_i(master_lock), .vpp_ok_i(vpp_ok), .unlock_hv_i(unlock_hv),
    .suspend_i(suspend), .seq_busy_i(seq_busy), .seq_done_i(seq_done),
    .seq_fail_i(seq_fail), .erase_req_o(erase_req), .erase_blk_o(erase_blk)
  );

  always @(posedge clk) if (erase_req) req_cnt <= req_cnt + 1;

  function automatic logic [7:0] id_exp(logic [AW-1:0] a, logic [NBLK-1:0] lk, logic ml);
    logic [BKW-1:0] b = a[AW-1:BW];
    logic [BW-1:0]  o = a[BW-1:0];
    if (o == 2) return {7'b0, lk[b]};
    if (b == 0 && o == 0) return 8'h89;
    if (b == 0 && o == 1) return 8'hA6;
    if (b == 0 && o == 3) return {7'b0, ml};
    return 8'h00;
  endfunction

  function automatic logic [7:0] st_exp(logic busy, logic e5, logic e4, logic e3, logic e1);
    return {~busy, 1'b0, e5, e4, e3, 1'b0, e1, 1'b0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] cmd, logic [AW-1:0] a);
    @(posedge clk); #1 we = 1; wdata = cmd; addr = a;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
    @(posedge clk); #1 addr = a; re = 1;
    #1 v = rdata;
    @(posedge clk); #1 re = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int rc;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    array_data = 8'h5A;
    rd(0, v); chk("R1 array after reset", v, 8'h5A);
    chk("R1 no request", erase_req, 0);
    wr(8'h70, 0); rd(0, v); chk("R1 clean status", v, 8'h80);

    // R2: array passthrough, random data
    wr(8'hFF, 0);
    for (int i = 0; i < 20; i++) begin
      array_data = 8'($urandom);
      rd(AW'($urandom), v); chk("R2 array data", v, array_data);
    end

    // R3 / R13: identifier space, directed then random
    blk_lock = NBLK'($urandom); blk_lock[0] = 1'b1; master_lock = 1;
    wr(8'h90, 0);
    rd(0, v); chk("R3 manufacturer", v, 8'h89);
    rd(1, v); chk("R3 device", v, 8'hA6);
    rd(3, v); chk("R3 master lock", v, 8'h01);
    rd({4'd9, 16'd2}, v); chk("R3 block lock", v, id_exp({4'd9, 16'd2}, blk_lock, master_lock));
    for (int i = 0; i < 30; i++) begin
      logic [AW-1:0] a;
      a[AW-1:BW] = BKW'($urandom);
      a[BW-1:0]  = ($urandom % 2) ? BW'($urandom % 5) : BW'($urandom);
      vpp_ok = 1'($urandom);
      if (i % 7 == 0) begin blk_lock = NBLK'($urandom); master_lock = 1'($urandom); end
      rd(a, v); chk("R3 R13 id read", v, id_exp(a, blk_lock, master_lock));
    end
    vpp_ok = 1; blk_lock = 0; master_lock = 0;

    // R4: status mode persists across unrecognised bytes
    array_data = 8'h11;
    wr(8'h70, 0); wr(8'h00, 0); rd(0, v); chk("R4 unrecognised byte", v, 8'h80);
    wr(8'hD0, 0); rd(0, v); chk("R4 lone confirm", v, 8'h80);
    chk("R4 lone confirm no request", req_cnt, 0);

    // R5: ready bit follows busy
    seq_busy = 1; rd(0, v); chk("R5 busy status", v, st_exp(1, 0, 0, 0, 0));
    seq_busy = 0;

    // R6: valid erase from array mode
    wr(8'hFF, 0); wr(8'h20, {4'd5, 16'h1234}); wr(8'hD0, {4'd5, 16'h1234});
    chk("R6 request pulse", erase_req, 1);
    chk("R6 block index", erase_blk, 5);
    @(posedge clk); #1 chk("R6 pulse one cycle", erase_req, 0);
    rd(0, v); chk("R6 reads status", v, 8'h80);

    // R7: malformed sequence with a mode command as second byte
    rc = req_cnt;
    wr(8'hFF, 0); wr(8'h20, 0); wr(8'hFF, 0);
    rd(0, v); chk("R7 sequence error", v, st_exp(0, 1, 1, 0, 0));
    chk("R7 no request", req_cnt, rc);

    // R11: sticky, clear blocked during suspend
    wr(8'hFF, 0); wr(8'h70, 0); rd(0, v); chk("R11 sticky kept", v, 8'hB0);
    suspend = 1; wr(8'h50, 0); rd(0, v); chk("R11 clear ignored in suspend", v, 8'hB0);
    suspend = 0; wr(8'h50, 0); rd(0, v); chk("R11 clear", v, 8'h80);

    // R8: voltage fault, also with a locked block (priority)
    vpp_ok = 0; blk_lock[2] = 1;
    wr(8'h20, {4'd2, 16'h0}); wr(8'hD0, {4'd2, 16'h0});
    rd(0, v); chk("R8 voltage error", v, st_exp(0, 1, 0, 1, 0));
    chk("R8 no request", req_cnt, rc);
    vpp_ok = 1; blk_lock = 0; wr(8'h50, 0);

    // R9: lock fault, then override
    blk_lock[3] = 1;
    wr(8'h20, {4'd3, 16'h40}); wr(8'hD0, {4'd3, 16'h40});
    rd(0, v); chk("R9 lock error", v, st_exp(0, 1, 0, 0, 1));
    chk("R9 no request", req_cnt, rc);
    wr(8'h50, 0); unlock_hv = 1;
    wr(8'h20, {4'd3, 16'h40}); wr(8'hD0, {4'd3, 16'h40});
    chk("R9 override request", erase_req, 1);
    chk("R9 override block", erase_blk, 3);
    rd(0, v); chk("R9 override status", v, 8'h80);
    unlock_hv = 0; blk_lock = 0;

    // R10: sequencer failure
    @(posedge clk); #1 seq_done = 1; seq_fail = 1;
    @(posedge clk); #1 seq_done = 0; seq_fail = 0;
    rd(0, v); chk("R10 erase failure", v, st_exp(0, 1, 0, 0, 0));
    wr(8'h50, 0);

    // R12: snapshot held during strobe
    @(posedge clk); #1 re = 1;
    #1 chk("R12 first cycle", rdata, 8'h80);
    @(posedge clk); #1 seq_busy = 1;
    #1 chk("R12 held after change", rdata, 8'h80);
    @(posedge clk); #2 chk("R12 still held", rdata, 8'h80);
    @(posedge clk); #1 re = 0;
    #1 chk("R12 released", rdata, 8'h00);
    seq_busy = 0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule